// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block makes the keep-or-drop decision for an incoming Ethernet frame from its 48-bit destination address alone. The parser upstream pulses a strobe together with the address, and one cycle later the filter returns a single-cycle verdict. The verdict is accept or reject, with a code that says why. Frame parsing, checksum validation and buffering belong to other blocks.

Four exact-match address slots are held in the filter. It also holds a 64-bit multicast hash table, indexed by a 6-bit XOR fold of the address, and three policy bits. The policy bits are copy-everything, refuse-broadcast and hash-enable. Software programs all of this state through a simple word-write port. With every hash-table bit set, the filter takes all multicast traffic.

The address bus carries the first byte on the wire in bits [7:0] and the sixth byte in bits [47:40]. Address bit j is therefore bus bit j, which is bit j mod 8 of byte j/8.

Top module: `rxaf_filter`

## Requirements
- R1: After reset, every slot, both hash words and all policy bits are zero, and `res_valid`, `res_accept`, `res_reason` and `res_slot` are all zero.
- R2: A lookup strobed on `da_valid` in one cycle produces `res_valid` high for exactly the next cycle. A cycle without a strobe is followed by `res_valid` low.
- R3: A write with `wr_en` high updates one register, chosen by `wr_addr`:
  - 2k loads slot k's low word: bytes 0..3, byte 0 in bits [7:0].
  - 2k+1 loads slot k's high word from `wr_data[15:0]`: byte 4 in [7:0], byte 5 in [15:8].
  - 8 loads hash-table bits 31..0.
  - 9 loads hash-table bits 63..32.
  - 10 loads the policy bits: bit 0 copy-everything, bit 1 refuse-broadcast, bit 2 hash-enable.
- R4: An address equal to a non-empty slot is accepted with reason 1 and `res_slot` set to that slot's index. When several slots match, the lowest index wins.
- R5: A slot whose low and high words are both zero is empty and never matches, even for the all-zero address.
- R6: Hash bit i, for i = 0..5, is the XOR of address bits i, i+6, i+12, …, i+42. All 48 address bits take part.
- R7: The hash value selects one table bit. Values 0..31 select a bit of the word at address 8, and values 32..63 select a bit of the word at address 9.
- R8: A hash hit is accepted with reason 2 only when hash-enable is set and the group bit (address bit 0) is set. Otherwise the hash is ignored.
- R9: With copy-everything set, every address is accepted with reason 4, including broadcast when refuse-broadcast is also set.
- R10: The all-ones address is judged before the slots and the hash. It is accepted with reason 3 when refuse-broadcast is clear, and rejected when refuse-broadcast is set.
- R11: A rejected address gives `res_accept` 0, `res_reason` 0 and `res_slot` 0.
- R12: A register write in the same cycle as a strobe does not affect that lookup. The lookup sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Destination-address strobe |
| da_addr | input | 48 | Destination address, wire byte 0 in [7:0] |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 reject, 1 slot, 2 hash, 3 broadcast, 4 copy-everything |
| res_slot | output | 2 | Matching slot index for reason 1, otherwise 0 |

## Verification
The properties assume that `da_addr` and the write port are stable and free of unknowns whenever they are sampled. They also assume that no write is issued to a register index above 10. The bench drives every input on the falling clock edge and keeps the strobe to a single cycle. It reads each verdict on the falling edge after the capturing rising edge. The one deliberate overlap of a write and a strobe is there to show that the lookup uses the register contents from before the write.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int unsigned MAC_W  = 48;
  localparam int unsigned HASH_W = 6;
  localparam int unsigned TBL_W  = 1 << HASH_W;

  typedef enum logic [2:0] {
    RSN_REJECT  = 3'd0,
    RSN_SLOT    = 3'd1,
    RSN_HASH    = 3'd2,
    RSN_BCAST   = 3'd3,
    RSN_PROMISC = 3'd4
  } reason_e;
endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned TBL_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NSLOT*ADDR_W-1:0]   slot_addr_o,
  output logic [TBL_W-1:0]          tbl_o,
  output logic                      copy_all_o,
  output logic                      no_bcast_o,
  output logic                      hash_en_o
);
  localparam int unsigned HI_W      = ADDR_W - DATA_W;
  localparam int unsigned TBL_WORDS = TBL_W / DATA_W;
  localparam int unsigned IDX_TBL   = 2 * NSLOT;
  localparam int unsigned IDX_CFG   = IDX_TBL + TBL_WORDS;
  localparam int unsigned CFG_W     = 3;

  // slot storage: low word then high word per slot
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [DATA_W-1:0] lo_q, lo_d;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic              lo_en, hi_en;

    always_comb begin
      lo_en = wr_en && (wr_addr == REG_AW'(2 * k));
      hi_en = wr_en && (wr_addr == REG_AW'(2 * k + 1));
      lo_d  = wr_data;
      hi_d  = wr_data[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_en) lo_q <= lo_d;
        if (hi_en) hi_q <= hi_d;
      end
    end

    assign slot_addr_o[k*ADDR_W +: ADDR_W] = {hi_q, lo_q};
  end

  // hash table words
  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
    logic [DATA_W-1:0] word_q, word_d;
    logic              word_en;

    always_comb begin
      word_en = wr_en && (wr_addr == REG_AW'(IDX_TBL + w));
      word_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign tbl_o[w*DATA_W +: DATA_W] = word_q;
  end

  // policy bits
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = wr_en && (wr_addr == REG_AW'(IDX_CFG));
    cfg_d  = wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign copy_all_o = cfg_q[0];
  assign no_bcast_o = cfg_q[1];
  assign hash_en_o  = cfg_q[2];

  // R3: a policy write is visible on the next cycle
  p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> ({hash_en_o, no_bcast_o, copy_all_o} == $past(wr_data[CFG_W-1:0])));
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned HASH_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [HASH_W-1:0] hash_o
);
  // every address bit folds into hash bit (bit mod HASH_W)
  always_comb begin
    hash_o = '0;
    for (int b = 0; b < ADDR_W; b++) begin
      hash_o[b % HASH_W] = hash_o[b % HASH_W] ^ addr_i[b];
    end
  end
endmodule

// File: rtl/rxaf_slot_cmp.sv
module rxaf_slot_cmp #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned ADDR_W = 48,
  localparam int unsigned SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [NSLOT*ADDR_W-1:0] slot_addr_i,
  output logic                    any_o,
  output logic [SEL_W-1:0]        sel_o
);
  logic [NSLOT-1:0] hit;

  for (genvar k = 0; k < NSLOT; k++) begin : g_cmp
    logic [ADDR_W-1:0] entry;
    assign entry  = slot_addr_i[k*ADDR_W +: ADDR_W];
    assign hit[k] = (entry != '0) && (entry == addr_i);
  end

  // lowest index has priority
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (hit[k]) begin
        any_o = 1'b1;
        sel_o = SEL_W'(k);
      end
    end
  end
endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 4,
  localparam int unsigned ADDR_W = rxaf_pkg::MAC_W,
  localparam int unsigned HASH_W = rxaf_pkg::HASH_W,
  localparam int unsigned TBL_W  = rxaf_pkg::TBL_W,
  localparam int unsigned SEL_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic [47:0]       da_addr,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              res_valid,
  output logic              res_accept,
  output logic [2:0]        res_reason,
  output logic [1:0]        res_slot
);
  import rxaf_pkg::*;

  logic [NSLOT*ADDR_W-1:0] slot_addr;
  logic [TBL_W-1:0]        tbl;
  logic                    copy_all, no_bcast, hash_en;
  logic [HASH_W-1:0]       hash_idx;
  logic                    slot_any;
  logic [SEL_W-1:0]        slot_sel;

  rxaf_regs #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .TBL_W(TBL_W),
    .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slot_addr_o(slot_addr), .tbl_o(tbl),
    .copy_all_o(copy_all), .no_bcast_o(no_bcast), .hash_en_o(hash_en)
  );

  rxaf_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
    .addr_i(da_addr), .hash_o(hash_idx)
  );

  rxaf_slot_cmp #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_cmp (
    .addr_i(da_addr), .slot_addr_i(slot_addr),
    .any_o(slot_any), .sel_o(slot_sel)
  );

  // decision, next-state side
  logic       is_bcast, is_group, tbl_hit;
  logic       acc_d, vld_d;
  reason_e    rsn_d;
  logic [1:0] slot_d;

  always_comb begin
    is_bcast = &da_addr;
    is_group = da_addr[0];
    tbl_hit  = tbl[hash_idx];
    acc_d    = 1'b0;
    rsn_d    = RSN_REJECT;
    slot_d   = '0;
    if (copy_all) begin
      acc_d = 1'b1;
      rsn_d = RSN_PROMISC;
    end else if (is_bcast) begin
      if (!no_bcast) begin
        acc_d = 1'b1;
        rsn_d = RSN_BCAST;
      end
    end else if (slot_any) begin
      acc_d  = 1'b1;
      rsn_d  = RSN_SLOT;
      slot_d = 2'(slot_sel);
    end else if (hash_en && is_group && tbl_hit) begin
      acc_d = 1'b1;
      rsn_d = RSN_HASH;
    end
    vld_d = da_valid;
    if (!da_valid) begin
      acc_d  = 1'b0;
      rsn_d  = RSN_REJECT;
      slot_d = '0;
    end
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= 3'd0;
      res_slot   <= 2'd0;
    end else begin
      res_valid  <= vld_d;
      res_accept <= acc_d;
      res_reason <= rsn_d;
      res_slot   <= slot_d;
    end
  end

  // R2: one verdict per strobe, exactly one cycle later
  p_strobe_to_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid);
  p_no_strobe_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid);
  // R11: reject carries zero codes
  p_reject_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (res_reason == 3'd0 && res_slot == 2'd0));
  // R9: copy-everything overrides all checks
  p_promisc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && copy_all) |=> (res_accept && res_reason == 3'd4));
  // R10: refused broadcast is dropped when not copying everything
  p_nobcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !copy_all && no_bcast && (&da_addr)) |=> !res_accept);
  // R8: without hash enable a non-slot, non-broadcast address is dropped
  p_hash_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !copy_all && !(&da_addr) && !slot_any && !hash_en) |=> !res_accept);
endmodule

// File: tb/rxaf_filter_test.sv
module rxaf_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        res_valid, res_accept;
  logic [2:0]  res_reason;
  logic [1:0]  res_slot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rxaf_filter uut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_valid(res_valid), .res_accept(res_accept),
    .res_reason(res_reason), .res_slot(res_slot)
  );

  // {addr, accept, reason, slot}; config: slots 1,2 = 55:44:33:22:11:00,
  // slot 3 = ..:02, hash bits 1 and 32 set, hash enabled
  localparam int NV = 12;
  localparam logic [53:0] VEC [NV] = '{
    {48'h5544_3322_1100, 1'b1, 3'd1, 2'd1},  // R4 lowest of two equal slots
    {48'h0000_0000_0002, 1'b1, 3'd1, 2'd3},  // R4 slot 3
    {48'h0000_0000_0000, 1'b0, 3'd0, 2'd0},  // R5 empty slot 0
    {48'hFFFF_FFFF_FFFF, 1'b1, 3'd3, 2'd0},  // R10 broadcast accepted
    {48'h0000_0000_0001, 1'b1, 3'd2, 2'd0},  // R6 hash 1, R7 bottom word
    {48'h0000_0000_0061, 1'b1, 3'd2, 2'd0},  // R6 hash 32, R7 top word
    {48'h0000_0000_0003, 1'b0, 3'd0, 2'd0},  // R6 hash 3 not set
    {48'h0000_0000_0021, 1'b0, 3'd0, 2'd0},  // R7 hash 33 not set
    {48'h8400_0000_0001, 1'b1, 3'd2, 2'd0},  // R6 high bits fold to 32
    {48'h0000_0000_0040, 1'b0, 3'd0, 2'd0},  // R8 unicast hashing to 1
    {48'h0011_2233_4455, 1'b0, 3'd0, 2'd0},  // R4 reversed byte order
    {48'h5544_3322_1000, 1'b0, 3'd0, 2'd0}   // R11 near miss
  };

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got {v,acc,rsn,slot}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [47:0] a,
                      input logic acc, input logic [2:0] rsn, input logic [1:0] sl);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a;
    @(negedge clk);
    da_valid = 1'b0;
    check(req, {res_valid, res_accept, res_reason, res_slot}, {1'b1, acc, rsn, sl});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs after reset
    check("R1", {res_valid, res_accept, res_reason, res_slot}, 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {res_valid, res_accept, res_reason, res_slot}, 7'b0);
    look("R1", 48'h0000_0000_0001, 1'b0, 3'd0, 2'd0);
    look("R1", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd3, 2'd0);
    // R2: no strobe, no verdict
    @(negedge clk);
    check("R2", {res_valid, res_accept, res_reason, res_slot}, 7'b0);

    // R3: program registers
    wr(4'd2, 32'h3322_1100); wr(4'd3, 32'h0000_5544);
    wr(4'd4, 32'h3322_1100); wr(4'd5, 32'h0000_5544);
    wr(4'd6, 32'h0000_0002);
    wr(4'd8, 32'h0000_0002); wr(4'd9, 32'h0000_0001);
    wr(4'd10, 32'h0000_0004);

    for (int i = 0; i < NV; i++) begin
      look("R3/R4/R6/R7/R8/R11 table", VEC[i][53:6], VEC[i][5], VEC[i][4:2], VEC[i][1:0]);
    end

    // R8: hash disabled
    wr(4'd10, 32'h0000_0000);
    look("R8", 48'h0000_0000_0001, 1'b0, 3'd0, 2'd0);
    // R10: refuse broadcast, even with full table and hash on
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd10, 32'h0000_0006);
    look("R10", 48'hFFFF_FFFF_FFFF, 1'b0, 3'd0, 2'd0);
    look("R7", 48'h0000_0000_0021, 1'b1, 3'd2, 2'd0);
    // R9: copy everything
    wr(4'd10, 32'h0000_0007);
    look("R9", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd4, 2'd0);
    look("R9", 48'h0000_0000_0004, 1'b1, 3'd4, 2'd0);
    wr(4'd10, 32'h0000_0000);

    // R12: write overlapping a lookup uses old contents
    @(negedge clk);
    da_valid = 1'b1; da_addr = 48'h0000_0000_0002;
    wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'h0000_0007;
    @(negedge clk);
    da_valid = 1'b0; wr_en = 1'b0;
    check("R12", {res_valid, res_accept, res_reason, res_slot}, {1'b1, 1'b1, 3'd1, 2'd3});
    look("R12", 48'h0000_0000_0007, 1'b1, 3'd1, 2'd3);
    look("R12", 48'h0000_0000_0002, 1'b0, 3'd0, 2'd0);
    // R5: clearing slot 3 empties it
    wr(4'd6, 32'h0000_0000);
    look("R5", 48'h0000_0000_0000, 1'b0, 3'd0, 2'd0);
    // R2: valid for one cycle only
    @(negedge clk);
    check("R2", {res_valid, res_accept, res_reason, res_slot}, 7'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule